// File: doc/BRIEF.md
# Routable Interrupt Controller

This block gathers interrupt requests from a set of sources and steers each one to one of a small number of output interrupt lines. The low sources are wired to hardware request inputs and latch on a rising edge. The high sources have no hardware input. Software raises them by writing to the set region, and source `NUM_HW + t` acts as the inter-processor interrupt aimed at thread `t`.

Every source has its own 64-bit configuration word, which holds an enable, an output-line selector and a thread identifier. A source drives line `n` only when four things are true: it is pending, it is enabled, its selector equals `n`, and its thread identifier matches the instance's `THREAD_ID` parameter. Software reaches the block through a plain 64-bit register port. Each access picks one of four regions:

- configuration words
- pending read-back
- write-one-to-set
- write-one-to-clear

Read data is registered. Software is expected to zero every configuration word at start-up, and reset leaves them at zero in any case.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every configuration word reads 0, no source is pending, every `irq_out` bit is low and `bus_rdata` is 0.
- R2: A write to region 0 at byte address `8*i` stores the fields of word `i`: bit 31 is the enable, bits 30:8 are the thread ID, bits 3:0 are the line selector. A read returns these fields in the same positions and 0 in every other bit. Read data for region 0 or region 1 appears on `bus_rdata` in the cycle after the request. Region 1 returns the pending vector in bits 31:0.
- R3: A rising edge on `hw_irq_in[i]` makes source `i` pending at the next clock edge. It stays pending until it is cleared. A level held high after a clear does not make it pending again.
- R4: A write to region 2 makes pending every source whose data bit is 1. Zero bits leave their sources unchanged.
- R5: A write to region 3 clears every pending source whose data bit is 1. Zero bits leave their sources unchanged.
- R6: When a hardware rising edge and a clear hit the same source in the same cycle, the source ends up pending.
- R7: `irq_out[n]` is high exactly when at least one source is pending, enabled, has selector `n` and has thread ID equal to `THREAD_ID`.
- R8: A pending source does not drive any line if it is disabled, if its thread ID differs from `THREAD_ID`, or if its selector is `NUM_OUT` or more. It also does not drive a line other than the one it selects.
- R9: Sources `NUM_HW` and above have no hardware input and are raised only through region 2. Source `NUM_HW + t`, routed to the top line, serves as the inter-processor interrupt for thread `t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_in | input | NUM_HW | Hardware request inputs, synchronous to `clk`, rising-edge sensitive |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_region | input | 2 | 0 config, 1 pending read, 2 set, 3 clear |
| bus_addr | input | ADDR_W | Byte offset within the region (config word index in bits above 2) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| irq_out | output | NUM_OUT | Output interrupt lines |

## Verification
The bench keeps the default geometry of 32 sources, 16 hardware inputs and 5 lines, and overrides `THREAD_ID` to 3. With that value, both a matching and a non-matching thread ID fit into ordinary words, and the mismatch path becomes reachable. Because the top line is index 4, selector values 5 and 6 exercise the out-of-range route. The top half of the source range lets the bench raise inter-processor interrupts while the hardware inputs toggle beside them.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int BUS_W   = 64;
  localparam int TID_W   = 23;
  localparam int ROUTE_W = 4;
  localparam int EN_BIT  = 31;
  localparam int TID_LSB = 8;

  typedef enum logic [1:0] {
    RG_CFG  = 2'd0,
    RG_PEND = 2'd1,
    RG_SET  = 2'd2,
    RG_CLR  = 2'd3
  } region_e;

  typedef struct packed {
    logic               en;
    logic [TID_W-1:0]   tid;
    logic [ROUTE_W-1:0] route;
  } src_cfg_t;

  function automatic src_cfg_t word_to_cfg(input logic [BUS_W-1:0] w);
    src_cfg_t c;
    c.en    = w[EN_BIT];
    c.tid   = w[TID_LSB +: TID_W];
    c.route = w[ROUTE_W-1:0];
    return c;
  endfunction

  function automatic logic [BUS_W-1:0] cfg_to_word(input src_cfg_t c);
    logic [BUS_W-1:0] w;
    w                    = '0;
    w[EN_BIT]            = c.en;
    w[TID_LSB +: TID_W]  = c.tid;
    w[ROUTE_W-1:0]       = c.route;
    return w;
  endfunction

endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [BUS_W-1:0]     wr_data,
  output src_cfg_t             cfg_q [NUM_SRC]
);

  src_cfg_t wr_cfg;
  assign wr_cfg = word_to_cfg(wr_data);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{wr_data[BUS_W-1:EN_BIT+1], wr_data[TID_LSB-1:ROUTE_W]};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        cfg_q[g] <= wr_cfg;
    end
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 32,
  parameter int NUM_HW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  hw_in,
  input  logic [NUM_SRC-1:0] set_mask,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] hw_rise,
  output logic [NUM_SRC-1:0] pend_q
);

  logic [NUM_HW-1:0]  hw_q;
  logic [NUM_SRC-1:0] pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= hw_in;
  end

  always_comb begin
    hw_rise               = '0;
    hw_rise[NUM_HW-1:0]   = hw_in & ~hw_q;
  end

  // Any set source (edge or register) wins over a clear in the same cycle.
  assign pend_d = (pend_q & ~clr_mask) | set_mask | hw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_OUT   = 5,
  parameter int THREAD_ID = 0
) (
  input  src_cfg_t             cfg_q [NUM_SRC],
  input  logic [NUM_SRC-1:0]   pend_q,
  output logic [NUM_OUT-1:0]   lines
);

  logic [NUM_SRC-1:0] live;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      live[i] = pend_q[i] && cfg_q[i].en && (cfg_q[i].tid == TID_W'(THREAD_ID));
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_line
    always_comb begin
      lines[n] = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
        if (live[i] && (cfg_q[i].route == ROUTE_W'(n)))
          lines[n] = 1'b1;
    end
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_HW    = 16,
  parameter int NUM_OUT   = 5,
  parameter int THREAD_ID = 0,
  localparam int IDX_W    = $clog2(NUM_SRC),
  localparam int ADDR_W   = IDX_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_HW-1:0]  hw_irq_in,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [1:0]         bus_region,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [63:0]        bus_wdata,
  output logic [63:0]        bus_rdata,
  output logic [NUM_OUT-1:0] irq_out
);

  region_e            rg;
  logic               wr_any;
  logic               rd_any;
  logic [IDX_W-1:0]   idx;
  logic [NUM_SRC-1:0] set_mask;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] hw_rise;
  src_cfg_t           cfg_q [NUM_SRC];

  assign rg     = region_e'(bus_region);
  assign wr_any = bus_req && bus_we;
  assign rd_any = bus_req && !bus_we;
  assign idx    = bus_addr[ADDR_W-1:3];

  assign set_mask = (wr_any && rg == RG_SET) ? bus_wdata[NUM_SRC-1:0] : '0;
  assign clr_mask = (wr_any && rg == RG_CLR) ? bus_wdata[NUM_SRC-1:0] : '0;

  logic unused_bus_bits;
  assign unused_bus_bits = ^{bus_addr[2:0], bus_wdata[63:NUM_SRC]};

  irq_cfg_bank #(.NUM_SRC(NUM_SRC)) cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_any && rg == RG_CFG),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC), .NUM_HW(NUM_HW)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_in    (hw_irq_in),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .hw_rise  (hw_rise),
    .pend_q   (pend_q)
  );

  irq_line_merge #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .THREAD_ID(THREAD_ID)) merge_i (
    .cfg_q  (cfg_q),
    .pend_q (pend_q),
    .lines  (irq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_any) begin
      case (rg)
        RG_CFG:  bus_rdata <= cfg_to_word(cfg_q[idx]);
        RG_PEND: bus_rdata <= 64'(pend_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_OUT = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic               bus_we,
  input logic [1:0]         bus_region,
  input logic [63:0]        bus_wdata,
  input logic [63:0]        bus_rdata,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] hw_rise,
  input logic [NUM_OUT-1:0] irq_out
);

  logic wr_set, wr_clr, rd_pend;
  assign wr_set  = bus_req && bus_we && bus_region == 2'd2;
  assign wr_clr  = bus_req && bus_we && bus_region == 2'd3;
  assign rd_pend = bus_req && !bus_we && bus_region == 2'd1;

  p_pend_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |=> bus_rdata == 64'($past(pend_q)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_set && !wr_clr && hw_rise == '0) |=> $stable(pend_q));

  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (pend_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]));

  p_clr_soft_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && hw_rise == '0) |=> (pend_q & $past(bus_wdata[NUM_SRC-1:0])) == '0);

  p_idle_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> (irq_out == '0));

endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_region (bus_region),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pend_q     (pend_q),
  .hw_rise    (hw_rise),
  .irq_out    (irq_out)
);

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;

  localparam int NSRC = 32;
  localparam int NHW  = 16;
  localparam int NOUT = 5;
  localparam int TID  = 3;
  localparam int AW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NHW-1:0]  hw_irq_in = '0;
  logic            bus_req = 1'b0;
  logic            bus_we = 1'b0;
  logic [1:0]      bus_region = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic [63:0]     bus_wdata = '0;
  logic [63:0]     bus_rdata;
  logic [NOUT-1:0] irq_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  irq_route_ctrl #(.NUM_SRC(NSRC), .NUM_HW(NHW), .NUM_OUT(NOUT), .THREAD_ID(TID)) dut_i (
    .clk(clk), .rst_n(rst_n), .hw_irq_in(hw_irq_in),
    .bus_req(bus_req), .bus_we(bus_we), .bus_region(bus_region),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [63:0] cw(input bit en, input int tid, input int route);
    return (64'(en) << 31) | (64'(tid) << 8) | 64'(route);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int rg, input int addr, input logic [63:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_region = 2'(rg); bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int rg, input int addr, output logic [63:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_region = 2'(rg); bus_addr = AW'(addr);
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tidy();
    hw_irq_in = '0;
    for (int i = 0; i < NSRC; i++) bus_write(0, i * 8, 64'd0);
    bus_write(3, 0, 64'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 rdata", bus_rdata, 64'd0);
    check("R1 lines", 64'(irq_out), 64'd0);
    bus_read(1, 0, d);  check("R1 pending", d, 64'd0);
    bus_read(0, 40, d); check("R1 cfg5", d, 64'd0);
  endtask

  task automatic t_cfg();
    logic [63:0] d;
    bus_write(0, 24, cw(1, TID, 2) | 64'hABCD_0000_0000_00F0);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_region = 2'd0; bus_addr = AW'(24);
    check("R2 rdata before edge", bus_rdata, 64'd0);
    @(negedge clk);
    bus_req = 1'b0;
    check("R2 cfg fields", bus_rdata, cw(1, TID, 2));
    tidy();
  endtask

  task automatic t_hw_edge();
    logic [63:0] d;
    bus_write(0, 24, cw(1, TID, 2));
    @(negedge clk); hw_irq_in[3] = 1'b1;
    @(negedge clk);
    check("R3 edge sets pending line", 64'(irq_out), 64'b00100);
    repeat (3) @(negedge clk);
    check("R3 stays pending", 64'(irq_out), 64'b00100);
    bus_write(3, 0, 64'h8);
    check("R5 clear drops line", 64'(irq_out), 64'd0);
    repeat (2) @(negedge clk);
    bus_read(1, 0, d); check("R3 held level no retrigger", d, 64'd0);
    hw_irq_in[3] = 1'b0;
    @(negedge clk); hw_irq_in[3] = 1'b1;
    @(negedge clk);
    bus_read(1, 0, d); check("R3 new edge", d, 64'h8);
    tidy();
  endtask

  task automatic t_zero_bits();
    logic [63:0] d;
    bus_write(2, 0, 64'h0001_0021);
    bus_read(1, 0, d); check("R4 set bits", d, 64'h0001_0021);
    bus_write(2, 0, 64'h0);
    bus_read(1, 0, d); check("R4 zero set no effect", d, 64'h0001_0021);
    bus_write(3, 0, 64'h0);
    bus_read(1, 0, d); check("R5 zero clear no effect", d, 64'h0001_0021);
    bus_write(3, 0, 64'h0000_0020);
    bus_read(1, 0, d); check("R5 clear one bit", d, 64'h0001_0001);
    tidy();
  endtask

  task automatic t_same_cycle();
    logic [63:0] d;
    @(negedge clk);
    hw_irq_in[5] = 1'b1;
    bus_req = 1'b1; bus_we = 1'b1; bus_region = 2'd3; bus_addr = '0; bus_wdata = 64'h20;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    bus_read(1, 0, d); check("R6 edge beats clear", d, 64'h20);
    tidy();
  endtask

  task automatic t_masking();
    bus_write(2, 0, 64'h80);
    bus_write(0, 56, cw(0, TID, 1));
    check("R8 disabled", 64'(irq_out), 64'd0);
    bus_write(0, 56, cw(1, 4, 1));
    check("R8 other thread", 64'(irq_out), 64'd0);
    bus_write(0, 56, cw(1, TID, 6));
    check("R8 route 6", 64'(irq_out), 64'd0);
    bus_write(0, 56, cw(1, TID, 5));
    check("R8 route 5", 64'(irq_out), 64'd0);
    bus_write(0, 56, cw(1, TID, 1));
    check("R7 line 1 only", 64'(irq_out), 64'b00010);
    bus_write(2, 0, 64'h1);
    bus_write(0, 0, cw(1, TID, 0));
    check("R7 two lines", 64'(irq_out), 64'b00011);
    tidy();
  endtask

  task automatic t_ipi();
    logic [63:0] d;
    bus_write(0, (NHW + TID) * 8, cw(1, TID, NOUT - 1));
    @(negedge clk); hw_irq_in = '1;
    @(negedge clk);
    bus_read(1, 0, d); check("R9 hw cannot reach soft half", d, 64'h0000_FFFF);
    bus_write(3, 0, 64'hFFFF);
    bus_write(2, 0, 64'(1) << (NHW + TID));
    check("R9 ipi on top line", 64'(irq_out), 64'b10000);
    bus_write(3, 0, 64'(1) << (NHW + TID));
    check("R9 ipi cleared", 64'(irq_out), 64'd0);
    tidy();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_hw_edge();
    t_zero_bits();
    t_same_cycle();
    t_masking();
    t_ipi();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule